// File: doc/BRIEF.md
# Switchable Instruction Fetch Cache

This block sits between a processor's instruction fetch port and a 16-bit external bus. It holds 1 KB of instructions as 128 direct-mapped lines of 8 bytes. While it is enabled, a fetch that finds its line returns the 32-bit word one cycle later without touching the bus. A fetch that misses reads the whole line over the bus as four 16-bit beats, stores the line, then answers.

Software controls the cache through two inputs. A level `ctl_enable` selects cached or uncached operation. A one-cycle `ctl_clear` pulse invalidates every line. Turning the cache off does not discard anything. Uncached fetches go straight to the bus and never allocate, and a later enable finds the earlier lines still usable. This lets code turn the cache on only around hot loops and keep what it loaded across the gaps. Lines are dropped only by an explicit clear, which walks the tag store one line per cycle.

The fetch side takes a word address (the byte address shifted right by two). The bus side gives byte addresses and a request that is held until it is acknowledged.

Top module: `fetch_icache`

## Requirements
- R1: After reset every line is invalid and `fetch_rdy` and `bus_req` are low, so the first enabled fetch to any address refills its line.
- R2: When enabled, a fetch whose line is valid with a matching tag raises `fetch_rdy` in the cycle after the edge that accepts it. `fetch_data` carries the word, and `bus_req` stays low.
- R3: An enabled miss reads the line as four 16-bit beats at line base +0, +2, +4, +6, in that order. Beat k supplies line bytes 2k (low half) and 2k+1. `fetch_addr[0]` picks the low word (beats 1:0) or the high word (beats 3:2), returned as {odd beat, even beat}. `fetch_rdy` rises in the cycle after the final acknowledge.
- R4: A line is marked valid only once all four beats have arrived. A later fetch of either word of that line hits.
- R5: When disabled, a fetch reads two beats at byte address {fetch_addr,2'b00} and +2 and returns {second, first}. It allocates nothing, so the same line still misses after re-enable.
- R6: Disabling the cache changes no tag, data or valid state. Lines filled before a disable hit after the next enable.
- R7: A clear invalidates all lines over 128 cycles, during which `fetch_rdy` and `bus_req` stay low. Suppose a fetch is presented in the same cycle as an idle-state clear pulse. Its bus access then starts in the 130th cycle after the pulse, and afterwards every line misses. A clear that arrives during a refill is held and runs once the refill ends.
- R8: The mapping is direct. Byte address bits [9:3] choose the line and bits [31:10] form the tag, so a fetch with the same index but another tag replaces the line.
- R9: While `bus_req` is high and `bus_ack` is low, `bus_req` and `bus_addr` hold their values.
- R10: `fetch_rdy` is a one-cycle pulse, once per accepted request. A request is accepted on an edge where `fetch_req` is high, `fetch_rdy` is low, and no clear is pending or running. The enable level is sampled on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_req | input | 1 | Fetch request, held until `fetch_rdy` |
| fetch_addr | input | 30 | Fetch word address (byte address >> 2) |
| fetch_rdy | output | 1 | One-cycle response strobe |
| fetch_data | output | 32 | Instruction word, valid with `fetch_rdy` |
| bus_req | output | 1 | Bus read request |
| bus_addr | output | 32 | Bus byte address of the current beat |
| bus_ack | input | 1 | Beat completes on an edge where this is high |
| bus_rdata | input | 16 | Beat data, valid with `bus_ack` |
| ctl_enable | input | 1 | 1 = cached operation, 0 = bypass with contents kept |
| ctl_clear | input | 1 | One-cycle pulse that invalidates all lines |

## Verification
The bench uses the default parameters: 128 lines of 8 bytes, a 16-bit bus and 32-bit words. The full 128-cycle clear walk is therefore timed exactly against a fetch queued behind it. Random addresses are drawn from three tags over 32 line indices, so hits, conflict evictions between tags and both word halves of a line all come up often. Enable toggles and clears are mixed in, and bus acknowledges arrive after random waits, so the address-hold and retention behaviour is exercised under stalls.

// File: rtl/icache_pkg.sv
// Package: shared types for the fetch cache.
// Assumes: nothing beyond the IEEE 1800-2017 enum rules.
package icache_pkg;

    // Controller states: idle/lookup, clear walk, line refill, uncached read
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CLEAR  = 2'd1,
        ST_FILL   = 2'd2,
        ST_BYPASS = 2'd3
    } ic_state_e;

endpackage

// File: rtl/icache_tag_store.sv
// Module: icache_tag_store
// Holds one tag and one valid bit per line. Reads are combinational. Writes
// set a line valid with a new tag, and a separate invalidate port clears one
// valid bit per cycle.
// Assumes: write and invalidate never target the same line in one cycle
// (the controller only invalidates while no refill runs).
module icache_tag_store #(
    parameter int NUM_LINES = 128,
    parameter int TAG_W     = 22,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             inv_en,
    input  logic [IDX_W-1:0] inv_idx
);

    logic [NUM_LINES-1:0] valid_q;
    logic [TAG_W-1:0]     tag_q [NUM_LINES];

    // Valid bits: cleared by reset or invalidate, set by a completed refill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            if (inv_en) valid_q[inv_idx] <= 1'b0;
            if (wr_en)  valid_q[wr_idx]  <= 1'b1;
        end
    end

    // Tag array: written only when a refill completes
    always_ff @(posedge clk) begin
        if (wr_en) tag_q[wr_idx] <= wr_tag;
    end

    // Lookup read port
    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_tag   = tag_q[rd_idx];
    end

endmodule

// File: rtl/icache_data_store.sv
// Module: icache_data_store
// One full line of instruction bytes per entry. It has one combinational read
// port and one write port that writes a whole line.
// Assumes: contents are meaningful only where the tag store marks the line valid.
module icache_data_store #(
    parameter int NUM_LINES = 128,
    parameter int LINE_W    = 64,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [LINE_W-1:0] wr_line
);

    logic [LINE_W-1:0] line_q [NUM_LINES];

    // Line array write
    always_ff @(posedge clk) begin
        if (wr_en) line_q[wr_idx] <= wr_line;
    end

    // Lookup read port
    assign rd_line = line_q[rd_idx];

endmodule

// File: rtl/icache_refill.sv
// Module: icache_refill
// Bus beat sequencer. On start it captures a base byte address and the index
// of the last beat. It then holds bus_req with ascending addresses, one beat
// per acknowledge. Beats land in a line-wide buffer, and line_next shows the
// buffer with the current beat already merged, so the final beat can be
// consumed in the cycle it arrives.
// Assumes: start is only pulsed while not busy; base is beat-aligned.
module icache_refill #(
    parameter int ADDR_W = 32,
    parameter int BUS_W  = 16,
    parameter int LINE_W = 64,
    localparam int BEATS     = LINE_W / BUS_W,
    localparam int CNT_W     = $clog2(BEATS),
    localparam int BUS_BYTES = BUS_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  last_idx,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_ack,
    input  logic [BUS_W-1:0]  bus_rdata,
    output logic              last_beat,
    output logic [LINE_W-1:0] line_next
);

    logic              busy_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  last_q;
    logic [ADDR_W-1:0] base_q;
    logic [LINE_W-1:0] line_q;
    logic              beat_done;

    assign beat_done = busy_q && bus_ack;
    assign last_beat = beat_done && (cnt_q == last_q);
    assign bus_req   = busy_q;
    assign bus_addr  = base_q + ADDR_W'(cnt_q) * ADDR_W'(BUS_BYTES);

    // Merge the arriving beat into its slot of the line buffer
    for (genvar j = 0; j < BEATS; j++) begin : g_slot
        assign line_next[j*BUS_W +: BUS_W] =
            (beat_done && cnt_q == CNT_W'(j)) ? bus_rdata : line_q[j*BUS_W +: BUS_W];
    end

    // Sequencer state: busy flag, beat counter, captured base and last index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            last_q <= '0;
            base_q <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            last_q <= last_idx;
            base_q <= start_addr;
        end else if (last_beat) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (beat_done) begin
            cnt_q  <= cnt_q + CNT_W'(1);
        end
    end

    // Line buffer: keeps every beat received so far
    always_ff @(posedge clk) begin
        if (!rst_n)         line_q <= '0;
        else if (beat_done) line_q <= line_next;
    end

endmodule

// File: rtl/fetch_icache.sv
// Module: fetch_icache (top)
// Direct-mapped instruction cache with bypass and clear control. In idle it
// looks up the fetch address combinationally and registers either a hit
// response or the start of a refill (enabled) or an uncached read (disabled).
// A clear pulse starts, or queues, a walk that invalidates one line per cycle.
// Assumes: fetch_req is held until fetch_rdy; fetch_addr is a word address;
// LINE_BYTES holds at least two words and the bus is at most one word wide.
module fetch_icache
    import icache_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 8,
    parameter int NUM_LINES  = 128,
    parameter int BUS_W      = 16,
    parameter int WORD_W     = 32,
    localparam int WORD_BYTES = WORD_W / 8,
    localparam int WSEL_LO    = $clog2(WORD_BYTES),
    localparam int FA_W       = ADDR_W - WSEL_LO
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic [FA_W-1:0]   fetch_addr,
    output logic              fetch_rdy,
    output logic [WORD_W-1:0] fetch_data,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_ack,
    input  logic [BUS_W-1:0]  bus_rdata,
    input  logic              ctl_enable,
    input  logic              ctl_clear
);

    localparam int OFS_W      = $clog2(LINE_BYTES);
    localparam int IDX_W      = $clog2(NUM_LINES);
    localparam int WSEL_W     = OFS_W - WSEL_LO;
    localparam int WORDS      = LINE_BYTES / WORD_BYTES;
    localparam int TAG_W      = FA_W - WSEL_W - IDX_W;
    localparam int LINE_W     = LINE_BYTES * 8;
    localparam int LINE_BEATS = LINE_W / BUS_W;
    localparam int WORD_BEATS = WORD_W / BUS_W;
    localparam int CNT_W      = $clog2(LINE_BEATS);

    ic_state_e          state_q;
    logic [FA_W-1:0]    req_addr_q;
    logic               rdy_q;
    logic [WORD_W-1:0]  data_q;
    logic               clr_pend_q;
    logic [IDX_W-1:0]   clr_cnt_q;

    logic [IDX_W-1:0]   look_idx;
    logic [TAG_W-1:0]   look_tag;
    logic [WSEL_W-1:0]  look_sel;
    logic               rd_valid;
    logic [TAG_W-1:0]   rd_tag;
    logic [LINE_W-1:0]  rd_line;
    logic               hit;
    logic               clr_go;
    logic               accept;
    logic               start_fill;
    logic               start_byp;
    logic               ref_start;
    logic [ADDR_W-1:0]  ref_addr;
    logic [CNT_W-1:0]   ref_last;
    logic               last_beat;
    logic [LINE_W-1:0]  line_next;
    logic               line_wr;
    logic               clearing;

    // Pick one word out of a line by word-select value
    function automatic logic [WORD_W-1:0] pick_word(input logic [LINE_W-1:0] ln,
                                                    input logic [WSEL_W-1:0] sel);
        logic [WORD_W-1:0] w;
        w = ln[WORD_W-1:0];
        for (int k = 0; k < WORDS; k++) begin
            if (sel == WSEL_W'(k)) w = ln[k*WORD_W +: WORD_W];
        end
        return w;
    endfunction

    // Address split of the incoming word address
    assign look_sel = fetch_addr[WSEL_W-1:0];
    assign look_idx = fetch_addr[WSEL_W +: IDX_W];
    assign look_tag = fetch_addr[FA_W-1 -: TAG_W];

    // Lookup decision and refill start
    assign hit        = rd_valid && (rd_tag == look_tag);
    assign clr_go     = ctl_clear || clr_pend_q;
    assign accept     = (state_q == ST_IDLE) && !clr_go && !rdy_q && fetch_req;
    assign start_fill = accept && ctl_enable && !hit;
    assign start_byp  = accept && !ctl_enable;
    assign ref_start  = start_fill || start_byp;
    assign ref_addr   = start_fill ? {fetch_addr[FA_W-1:WSEL_W], OFS_W'(0)}
                                   : {fetch_addr, WSEL_LO'(0)};
    assign ref_last   = start_fill ? CNT_W'(LINE_BEATS - 1) : CNT_W'(WORD_BEATS - 1);

    assign line_wr  = (state_q == ST_FILL) && last_beat;
    assign clearing = (state_q == ST_CLEAR);

    icache_tag_store #(
        .NUM_LINES (NUM_LINES),
        .TAG_W     (TAG_W)
    ) tags_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (look_idx),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .wr_en    (line_wr),
        .wr_idx   (req_addr_q[WSEL_W +: IDX_W]),
        .wr_tag   (req_addr_q[FA_W-1 -: TAG_W]),
        .inv_en   (clearing),
        .inv_idx  (clr_cnt_q)
    );

    icache_data_store #(
        .NUM_LINES (NUM_LINES),
        .LINE_W    (LINE_W)
    ) data_i (
        .clk     (clk),
        .rd_idx  (look_idx),
        .rd_line (rd_line),
        .wr_en   (line_wr),
        .wr_idx  (req_addr_q[WSEL_W +: IDX_W]),
        .wr_line (line_next)
    );

    icache_refill #(
        .ADDR_W (ADDR_W),
        .BUS_W  (BUS_W),
        .LINE_W (LINE_W)
    ) refill_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (ref_start),
        .start_addr (ref_addr),
        .last_idx   (ref_last),
        .bus_req    (bus_req),
        .bus_addr   (bus_addr),
        .bus_ack    (bus_ack),
        .bus_rdata  (bus_rdata),
        .last_beat  (last_beat),
        .line_next  (line_next)
    );

    // Controller: state, response register, pending clear and clear walker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            req_addr_q <= '0;
            rdy_q      <= 1'b0;
            data_q     <= '0;
            clr_pend_q <= 1'b0;
            clr_cnt_q  <= '0;
        end else begin
            rdy_q <= 1'b0;
            if (ctl_clear && state_q != ST_IDLE) clr_pend_q <= 1'b1;
            case (state_q)
                ST_IDLE: begin
                    if (clr_go) begin
                        state_q    <= ST_CLEAR;
                        clr_cnt_q  <= '0;
                        clr_pend_q <= 1'b0;
                    end else if (accept) begin
                        req_addr_q <= fetch_addr;
                        if (!ctl_enable) begin
                            state_q <= ST_BYPASS;
                        end else if (hit) begin
                            rdy_q  <= 1'b1;
                            data_q <= pick_word(rd_line, look_sel);
                        end else begin
                            state_q <= ST_FILL;
                        end
                    end
                end
                ST_CLEAR: begin
                    clr_cnt_q <= clr_cnt_q + IDX_W'(1);
                    if (clr_cnt_q == IDX_W'(NUM_LINES - 1)) state_q <= ST_IDLE;
                end
                ST_FILL: begin
                    if (last_beat) begin
                        rdy_q   <= 1'b1;
                        data_q  <= pick_word(line_next, req_addr_q[WSEL_W-1:0]);
                        state_q <= ST_IDLE;
                    end
                end
                ST_BYPASS: begin
                    if (last_beat) begin
                        rdy_q   <= 1'b1;
                        data_q  <= line_next[WORD_W-1:0];
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign fetch_rdy  = rdy_q;
    assign fetch_data = data_q;

endmodule

// File: rtl/fetch_icache_chk.sv
// Module: fetch_icache_chk
// Protocol and timing checks for fetch_icache, attached by bind below.
// Assumes: the bus responder may stall any beat by holding bus_ack low.
module fetch_icache_chk #(
    parameter int ADDR_W    = 32,
    parameter int NUM_LINES = 128,
    parameter int BUS_W     = 16,
    localparam int RUN_W    = $clog2(NUM_LINES) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_rdy,
    input logic              bus_req,
    input logic              bus_ack,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              clearing
);

    logic [RUN_W-1:0] clr_run_q;

    // Length of the current run of clearing cycles
    always_ff @(posedge clk) begin
        if (!rst_n)        clr_run_q <= '0;
        else if (clearing) clr_run_q <= clr_run_q + RUN_W'(1);
        else               clr_run_q <= '0;
    end

    // R9: a stalled beat keeps its request and address
    a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr));

    // R3: beats inside one access step upward by one bus width
    a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_req && bus_ack) && bus_req |-> bus_addr == $past(bus_addr) + ADDR_W'(BUS_W / 8));

    // R10: the response strobe lasts a single cycle
    a_r10_rdy_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_rdy |=> !fetch_rdy);

    // R2: a response never overlaps bus activity
    a_r2_resp_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_rdy |-> !bus_req);

    // R7: the clear walk is silent on both ports
    a_r7_clear_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        clearing |-> !fetch_rdy && !bus_req);

    // R7: the walk never exceeds one cycle per line
    a_r7_clear_bound: assert property (@(posedge clk) disable iff (!rst_n)
        clearing |-> clr_run_q < RUN_W'(NUM_LINES));

    // R7: a finished walk covered every line
    a_r7_clear_full: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clearing) |-> clr_run_q == RUN_W'(NUM_LINES));

endmodule

bind fetch_icache fetch_icache_chk #(
    .ADDR_W    (ADDR_W),
    .NUM_LINES (NUM_LINES),
    .BUS_W     (BUS_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetch_rdy (fetch_rdy),
    .bus_req   (bus_req),
    .bus_ack   (bus_ack),
    .bus_addr  (bus_addr),
    .clearing  (clearing)
);

// File: tb/fetch_icache_tb.sv
// Bench for fetch_icache: directed corner cases, then seeded random traffic,
// checked against a bench-side tag model and a computed memory image.
module fetch_icache_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NLINES     = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_req = 1'b0;
    logic [29:0] fetch_addr = '0;
    logic        fetch_rdy;
    logic [31:0] fetch_data;
    logic        bus_req;
    logic [31:0] bus_addr;
    logic        bus_ack = 1'b0;
    logic [15:0] bus_rdata = '0;
    logic        ctl_enable = 1'b1;
    logic        ctl_clear = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    // Bench model of the tag store
    bit          m_en = 1'b1;
    bit          m_valid [NLINES];
    logic [21:0] m_tag   [NLINES];

    // Log of bus beats issued by the responder
    logic [31:0] blog [8];
    int          blog_n = 0;
    bit          prev_wait = 1'b0;
    logic [31:0] prev_addr = '0;

    fetch_icache dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_req  (fetch_req),
        .fetch_addr (fetch_addr),
        .fetch_rdy  (fetch_rdy),
        .fetch_data (fetch_data),
        .bus_req    (bus_req),
        .bus_addr   (bus_addr),
        .bus_ack    (bus_ack),
        .bus_rdata  (bus_rdata),
        .ctl_enable (ctl_enable),
        .ctl_clear  (ctl_clear)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Memory image: 16-bit value at an even byte address
    function automatic logic [15:0] memw(input logic [31:0] a);
        logic [15:0] t;
        t = a[16:1] * 16'h9E37;
        return t ^ a[31:16] ^ 16'h5A3C;
    endfunction

    function automatic logic [31:0] exp_word(input logic [31:0] a);
        return {memw(a + 32'd2), memw(a)};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    // Bus responder with random waits; also checks address hold (R9)
    always @(negedge clk) begin
        if (rst_n && bus_req) begin
            if (prev_wait)
                chk(bus_addr == prev_addr, "R9", "addr held in wait", bus_addr, prev_addr);
            bus_ack = ($urandom % 4) != 0;
            bus_rdata = memw(bus_addr);
            if (bus_ack && blog_n < 8) blog[blog_n] = bus_addr;
            if (bus_ack) blog_n++;
            prev_wait = !bus_ack;
            prev_addr = bus_addr;
        end else begin
            bus_ack = 1'b0;
            prev_wait = 1'b0;
        end
    end

    // Wait for the response, then confirm it is a single pulse (R10)
    task automatic wait_resp(output int cyc, output logic [31:0] got);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!fetch_rdy && cyc < 1000);
        got = fetch_data;
        fetch_req = 1'b0;
        @(negedge clk);
        chk(!fetch_rdy, "R10", "rdy single cycle", fetch_rdy, 0);
    endtask

    // Compare a finished access with the model and update the model
    task automatic judge(input logic [31:0] a, input bit hit, input bit en,
                         input logic [31:0] got, input string lbl);
        int          exp_n;
        logic [31:0] base;
        string       dreq;
        if (!en) begin
            exp_n = 2; base = {a[31:2], 2'b00}; dreq = "R5";
        end else if (hit) begin
            exp_n = 0; base = '0; dreq = "R2";
        end else begin
            exp_n = 4; base = {a[31:3], 3'b000}; dreq = "R3";
        end
        chk(got == exp_word(a), dreq, "fetch data", got, exp_word(a));
        chk(blog_n == exp_n, lbl, "bus beat count", blog_n, exp_n);
        for (int k = 0; k < exp_n && k < 8; k++)
            chk(blog[k] == base + 32'(2 * k), dreq, "beat address", blog[k], base + 32'(2 * k));
        if (en && !hit) begin
            m_valid[a[9:3]] = 1'b1;
            m_tag[a[9:3]]   = a[31:10];
        end
    endtask

    task automatic do_fetch(input logic [31:0] a, input string lbl);
        bit          hit;
        bit          en;
        int          cyc;
        logic [31:0] got;
        en  = m_en;
        hit = en && m_valid[a[9:3]] && (m_tag[a[9:3]] == a[31:10]);
        @(negedge clk);
        fetch_req  = 1'b1;
        fetch_addr = a[31:2];
        blog_n     = 0;
        wait_resp(cyc, got);
        if (hit) chk(cyc == 1, "R2", "hit latency", cyc, 1);
        judge(a, hit, en, got, lbl);
    endtask

    // Clear pulse together with a fetch; the fetch waits for the walk (R7)
    task automatic do_clear_fetch(input logic [31:0] a);
        int          quiet_n;
        bit          rdy_seen;
        int          cyc;
        logic [31:0] got;
        @(negedge clk);
        ctl_clear  = 1'b1;
        fetch_req  = 1'b1;
        fetch_addr = a[31:2];
        blog_n     = 0;
        quiet_n    = 0;
        rdy_seen   = 1'b0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            ctl_clear = 1'b0;
            if (bus_req) break;
            if (fetch_rdy) rdy_seen = 1'b1;
            quiet_n++;
        end
        chk(quiet_n == NLINES + 1, "R7", "cycles before bus start", quiet_n, NLINES + 1);
        chk(!rdy_seen, "R7", "no response during clear", rdy_seen, 0);
        for (int i = 0; i < NLINES; i++) m_valid[i] = 1'b0;
        wait_resp(cyc, got);
        judge(a, 1'b0, m_en, got, "R7");
    endtask

    task automatic set_enable(input bit v);
        @(negedge clk);
        ctl_enable = v;
        m_en = v;
    endtask

    // Watchdog: a hung run is a failure
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        report();
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < NLINES; i++) begin
            m_valid[i] = 1'b0;
            m_tag[i]   = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        chk(!fetch_rdy, "R1", "rdy after reset", fetch_rdy, 0);
        chk(!bus_req, "R1", "bus_req after reset", bus_req, 0);

        // R1/R3: first fetch refills; R4: other word of the line then hits
        do_fetch(32'h0000_1234 & ~32'h3, "R1");
        do_fetch(32'h0000_1230, "R4");
        do_fetch(32'h0000_1234, "R4");

        // R8: same index, different tag evicts
        do_fetch(32'h0000_0040, "R8");
        do_fetch(32'h0000_0440, "R8");
        do_fetch(32'h0000_0044, "R8");

        // R6: filled line survives a disable; R5: bypass reads never allocate
        do_fetch(32'h0000_2008, "R6");
        set_enable(1'b0);
        do_fetch(32'h0000_2008, "R5");
        do_fetch(32'h0000_3010, "R5");
        set_enable(1'b1);
        do_fetch(32'h0000_200C, "R6");
        do_fetch(32'h0000_3010, "R5");

        // R7: clear, then previously valid lines miss
        do_clear_fetch(32'h0000_1230);
        do_fetch(32'h0000_2008, "R7");

        // Random traffic over three tags and 32 lines
        for (int it = 0; it < 400; it++) begin
            int r;
            logic [31:0] a;
            r = $urandom % 100;
            a = 32'h0010_0000 | (32'($urandom % 3) << 10) | (32'($urandom % 32) << 3)
                | (32'($urandom % 2) << 2);
            if (r < 6)       set_enable(!m_en);
            else if (r < 8)  do_clear_fetch(a);
            else             do_fetch(a, m_en ? "R8" : "R5");
        end
        set_enable(1'b1);
        do_fetch(32'h0010_0000, "R4");
        do_fetch(32'h0010_0004, "R4");
        report();
    end

endmodule